// File: doc/BRIEF.md
# DSP Single-Data Transfer Unit

This block decodes and executes the single-data transfer group of a DSP datapath. Each instruction moves one value between a DSP data register and memory, as a 16-bit word or a 32-bit longword. In the same step it may update one of four address pointers. The unit is purely combinational and finishes every instruction in one execution state. The surrounding pipeline presents three things: the instruction word, the current pointer and index values, and the register file contents. It then takes the memory request, the register writeback and the pointer update from the outputs in that same state.

The pointer update depends on the addressing mode. The pointer can be decremented before the access, left unchanged, incremented by the access size after the access, or advanced after the access by an index value. Word loads are placed in the upper half of the destination register and the lower half is cleared. A word store sends the upper half of its source register. The two 8-bit guard registers are the exception: a word store from either of them is sign-extended to 32 bits.

Top module: `dsp_xfer_unit`

## Requirements
- R1: An instruction is executed only when `insn_vld` is 1 and `insn[15:10]` is 6'b111101. Otherwise `mem_rd`, `mem_wr`, `dreg_wb_en` and `ptr_wb_en` are all 0.
- R2: `insn[1:0]` selects size and direction: 00 word load, 01 word store, 10 longword load, 11 longword store. A load raises only `mem_rd`, a store raises only `mem_wr`. `mem_size` is 0 for word and 1 for longword.
- R3: Mode `insn[3:2]`=00 is pre-decrement. The pointer minus 2 (word) or minus 4 (longword) is both the memory address and the new pointer value.
- R4: Mode 01 is plain indirect. The address is the unmodified pointer and `ptr_wb_en` stays 0.
- R5: Mode 10 is post-increment. The address is the unmodified pointer, and the new pointer value is the pointer plus 2 (word) or plus 4 (longword).
- R6: Mode 11 is post-index. The address is the unmodified pointer, and the new pointer value is the pointer plus `idx_val`.
- R7: A word load writes `{mem_rdata[15:0], 16'h0000}` to the destination register.
- R8: A word store drives `mem_wdata` = `{16'h0000, Ds[31:16]}`.
- R9: A word store whose data code is 14 drives `mem_wdata` with `guard0` sign-extended from 8 to 32 bits. Data code 15 does the same with `guard1`.
- R10: A longword load writes all 32 bits of `mem_rdata`. A longword store drives all 32 bits of the selected register.
- R11: All pointer arithmetic wraps modulo 2^32.
- R12: `insn[9:8]` selects the pointer, which is reported on `ptr_wb_sel`. `insn[7:4]` selects the data register, which is reported on `dreg_wb_sel`. Pointer k sits at `ptr_regs[32k+31:32k]` and data register k at `dregs[32k+31:32k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 16 | Instruction word |
| insn_vld | input | 1 | Instruction valid strobe |
| ptr_regs | input | 128 | Four packed address pointers |
| idx_val | input | 32 | Index register value |
| dregs | input | 512 | Sixteen packed DSP data registers |
| guard0 | input | 8 | First guard register |
| guard1 | input | 8 | Second guard register |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_size | output | 1 | Access size, 0 word, 1 longword |
| mem_wdata | output | 32 | Memory write data |
| dreg_wb_en | output | 1 | Data register writeback enable |
| dreg_wb_sel | output | 4 | Data register writeback index |
| dreg_wb_data | output | 32 | Data register writeback value |
| ptr_wb_en | output | 1 | Pointer writeback enable |
| ptr_wb_sel | output | 2 | Pointer writeback index |
| ptr_wb_val | output | 32 | Updated pointer value |

## Verification
The bench steps a pointer over both ends of the 32-bit range in pre-decrement, post-increment and index modes. A design that carried or saturated its pointer arithmetic would return an address near the top of the range instead of a small wrapped one. It stores both guard registers, one with a negative value and one with a positive value. This exposes zero-extension, which gives the wrong upper bits for the negative case, and sign replication applied to positive values. Plain indirect mode is checked for a silent pointer write, and word loads are checked for leftover data in the low half. Near-miss opcodes and a deasserted valid strobe are applied to catch a decoder that ignores the upper bits.

// File: rtl/dsp_xfer_unit.sv
module dsp_xfer_unit #(
  parameter int DW   = 32,
  parameter int NPTR = 4,
  parameter int NREG = 16
) (
  input  logic [15:0]        insn,
  input  logic               insn_vld,
  input  logic [NPTR*DW-1:0] ptr_regs,
  input  logic [DW-1:0]      idx_val,
  input  logic [NREG*DW-1:0] dregs,
  input  logic [7:0]         guard0,
  input  logic [7:0]         guard1,
  input  logic [DW-1:0]      mem_rdata,
  output logic [DW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               mem_size,
  output logic [DW-1:0]      mem_wdata,
  output logic               dreg_wb_en,
  output logic [3:0]         dreg_wb_sel,
  output logic [DW-1:0]      dreg_wb_data,
  output logic               ptr_wb_en,
  output logic [1:0]         ptr_wb_sel,
  output logic [DW-1:0]      ptr_wb_val
);
  localparam int HW = DW / 2;
  localparam logic [5:0] GROUP = 6'b111101;
  localparam logic [1:0] M_PRE = 2'b00, M_IND = 2'b01, M_POST = 2'b10, M_IDX = 2'b11;
  localparam logic [3:0] G0_CODE = 4'd14, G1_CODE = 4'd15;

  logic          hit, is_long, is_store;
  logic [1:0]    mode;
  logic [DW-1:0] ptr, src, step, dec_ptr, next_ptr;

  assign hit      = insn_vld && (insn[15:10] == GROUP);
  assign is_long  = insn[1];
  assign is_store = insn[0];
  assign mode     = insn[3:2];
  assign ptr      = ptr_regs[insn[9:8]*DW +: DW];
  assign src      = dregs[insn[7:4]*DW +: DW];
  assign step     = is_long ? DW'(4) : DW'(2);
  assign dec_ptr  = ptr - step;

  always_comb begin
    case (mode)
      M_PRE:   next_ptr = dec_ptr;
      M_POST:  next_ptr = ptr + step;
      M_IDX:   next_ptr = ptr + idx_val;
      default: next_ptr = ptr;
    endcase
  end

  assign mem_addr   = (mode == M_PRE) ? dec_ptr : ptr;
  assign mem_rd     = hit && !is_store;
  assign mem_wr     = hit && is_store;
  assign mem_size   = is_long;

  always_comb begin
    if (is_long)
      mem_wdata = src;
    else if (insn[7:4] == G0_CODE)
      mem_wdata = {{(DW-8){guard0[7]}}, guard0};
    else if (insn[7:4] == G1_CODE)
      mem_wdata = {{(DW-8){guard1[7]}}, guard1};
    else
      mem_wdata = {{HW{1'b0}}, src[DW-1:HW]};
  end

  assign dreg_wb_en   = hit && !is_store;
  assign dreg_wb_sel  = insn[7:4];
  assign dreg_wb_data = is_long ? mem_rdata : {mem_rdata[HW-1:0], {HW{1'b0}}};

  assign ptr_wb_en  = hit && (mode != M_IND);
  assign ptr_wb_sel = insn[9:8];
  assign ptr_wb_val = next_ptr;

  always_comb begin
    // R1
    idle_quiet_chk: assert (hit || !(mem_rd || mem_wr || dreg_wb_en || ptr_wb_en));
    // R2
    rw_excl_chk: assert (!(mem_rd && mem_wr));
    // R4
    indirect_keep_chk: assert (!(hit && mode == M_IND) || !ptr_wb_en);
    // R7
    word_ld_low_chk: assert (!(dreg_wb_en && !mem_size) || dreg_wb_data[HW-1:0] == '0);
    // R5
    post_step_chk: assert (!(hit && mode == M_POST) ||
                           (ptr_wb_val - mem_addr) == (mem_size ? DW'(4) : DW'(2)));
    // R3
    pre_same_chk: assert (!(hit && mode == M_PRE) || ptr_wb_val == mem_addr);
  end
endmodule

// File: tb/dsp_xfer_unit_tb.sv
module dsp_xfer_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0]  insn;
  logic         insn_vld;
  logic [127:0] ptr_regs;
  logic [31:0]  idx_val;
  logic [511:0] dregs;
  logic [7:0]   guard0, guard1;
  logic [31:0]  mem_rdata;
  logic [31:0]  mem_addr, mem_wdata, dreg_wb_data, ptr_wb_val;
  logic         mem_rd, mem_wr, mem_size, dreg_wb_en, ptr_wb_en;
  logic [3:0]   dreg_wb_sel;
  logic [1:0]   ptr_wb_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dsp_xfer_unit dut_i (
    .insn(insn), .insn_vld(insn_vld), .ptr_regs(ptr_regs), .idx_val(idx_val),
    .dregs(dregs), .guard0(guard0), .guard1(guard1), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .dreg_wb_en(dreg_wb_en), .dreg_wb_sel(dreg_wb_sel),
    .dreg_wb_data(dreg_wb_data), .ptr_wb_en(ptr_wb_en), .ptr_wb_sel(ptr_wb_sel),
    .ptr_wb_val(ptr_wb_val)
  );

  function automatic logic [15:0] enc(input logic [1:0] as, input logic [3:0] ds,
                                      input logic [1:0] mode, input logic [1:0] op);
    return {6'b111101, as, ds, mode, op};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic v);
    @(negedge clk);
    insn = w;
    insn_vld = v;
    #1;
  endtask

  task automatic set_ptr(input int k, input logic [31:0] v);
    ptr_regs[k*32 +: 32] = v;
  endtask

  task automatic t_idle();
    apply(enc(2'd0, 4'd2, 2'b10, 2'b00), 1'b0);
    chk("R1", "idle strobes", {28'h0, mem_rd, mem_wr, dreg_wb_en, ptr_wb_en}, 32'h0);
    apply(16'hF500 ^ 16'h0400, 1'b1);
    chk("R1", "bad opcode strobes", {28'h0, mem_rd, mem_wr, dreg_wb_en, ptr_wb_en}, 32'h0);
    apply({6'b111100, 10'h2A}, 1'b1);
    chk("R1", "near opcode strobes", {28'h0, mem_rd, mem_wr, dreg_wb_en, ptr_wb_en}, 32'h0);
  endtask

  task automatic t_word_load_post();
    apply(enc(2'd0, 4'd2, 2'b10, 2'b00), 1'b1);
    chk("R2", "rd/wr/size", {29'h0, mem_rd, mem_wr, mem_size}, 32'b100);
    chk("R5", "addr", mem_addr, 32'h0000_1000);
    chk("R5", "ptr new", ptr_wb_val, 32'h0000_1002);
    chk("R5", "ptr en", {31'h0, ptr_wb_en}, 32'h1);
    chk("R7", "wb data", dreg_wb_data, 32'hBEEF_0000);
    chk("R12", "wb sel", {28'h0, dreg_wb_sel}, 32'd2);
    chk("R12", "ptr sel", {30'h0, ptr_wb_sel}, 32'd0);
  endtask

  task automatic t_long_load_pre();
    apply(enc(2'd1, 4'd5, 2'b00, 2'b10), 1'b1);
    chk("R3", "addr", mem_addr, 32'h0000_1FFC);
    chk("R3", "ptr new", ptr_wb_val, 32'h0000_1FFC);
    chk("R10", "wb data", dreg_wb_data, 32'hCAFE_BEEF);
    chk("R2", "size long", {31'h0, mem_size}, 32'h1);
    chk("R12", "ptr sel", {30'h0, ptr_wb_sel}, 32'd1);
  endtask

  task automatic t_word_store_ind();
    apply(enc(2'd1, 4'd3, 2'b01, 2'b01), 1'b1);
    chk("R2", "rd/wr/dwb", {29'h0, mem_rd, mem_wr, dreg_wb_en}, 32'b010);
    chk("R4", "addr", mem_addr, 32'h0000_2000);
    chk("R4", "ptr en", {31'h0, ptr_wb_en}, 32'h0);
    chk("R8", "wdata", mem_wdata, 32'h0000_1234);
    apply(enc(2'd0, 4'd7, 2'b01, 2'b00), 1'b1);
    chk("R4", "load ptr en", {31'h0, ptr_wb_en}, 32'h0);
  endtask

  task automatic t_long_store_idx();
    apply(enc(2'd0, 4'd3, 2'b11, 2'b11), 1'b1);
    chk("R6", "addr", mem_addr, 32'h0000_1000);
    chk("R6", "ptr new", ptr_wb_val, 32'h0000_1010);
    chk("R10", "wdata", mem_wdata, 32'h1234_5603);
  endtask

  task automatic t_guard();
    apply(enc(2'd0, 4'd14, 2'b01, 2'b01), 1'b1);
    chk("R9", "guard0 neg", mem_wdata, 32'hFFFF_FF85);
    apply(enc(2'd0, 4'd15, 2'b01, 2'b01), 1'b1);
    chk("R9", "guard1 pos", mem_wdata, 32'h0000_007F);
  endtask

  task automatic t_wrap();
    apply(enc(2'd3, 4'd1, 2'b10, 2'b10), 1'b1);
    chk("R11", "post wrap", ptr_wb_val, 32'h0000_0002);
    chk("R12", "ptr sel 3", {30'h0, ptr_wb_sel}, 32'd3);
    apply(enc(2'd2, 4'd1, 2'b00, 2'b10), 1'b1);
    chk("R11", "pre wrap addr", mem_addr, 32'hFFFF_FFFE);
    apply(enc(2'd2, 4'd1, 2'b00, 2'b00), 1'b1);
    chk("R3", "word pre", ptr_wb_val, 32'h0000_0000);
    idx_val = 32'hFFFF_FFF0;
    apply(enc(2'd0, 4'd1, 2'b11, 2'b00), 1'b1);
    chk("R11", "idx neg", ptr_wb_val, 32'h0000_0FF0);
    idx_val = 32'h10;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    insn = 16'h0;
    insn_vld = 1'b0;
    idx_val = 32'h10;
    guard0 = 8'h85;
    guard1 = 8'h7F;
    mem_rdata = 32'hCAFE_BEEF;
    ptr_regs = '0;
    set_ptr(0, 32'h0000_1000);
    set_ptr(1, 32'h0000_2000);
    set_ptr(2, 32'h0000_0002);
    set_ptr(3, 32'hFFFF_FFFE);
    for (int k = 0; k < 16; k++) dregs[k*32 +: 32] = 32'h1234_5600 | k;
    t_idle();
    t_word_load_post();
    t_long_load_pre();
    t_word_store_ind();
    t_long_store_idx();
    t_guard();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule